// File: doc/BRIEF.md
# Presence-Detect Serial Memory Slave

This block is a two-wire serial slave that behaves like a small presence-detect memory holding 256 bytes. It runs on a fast system clock. The clock line and the data line come in as open-drain bus levels, and each passes through a synchroniser before use. The block drives the data line through one pull-low enable. It never drives the line high.

A master begins every command with a start condition and then sends a device byte. The upper seven bits of that byte select this device, and its lowest bit chooses the direction. For a write, the first byte after the device byte loads an internal byte pointer. Each byte after that is stored at the pointer, and the pointer then advances. For a read, the block sends the byte at the pointer and keeps sending bytes for as long as the master acknowledges. A stop condition ends any transfer and returns the block to standby. A repeated start lets the master set the pointer with a dummy write and then read from that location.

Top module: `pd_eeprom_slave`

## Requirements
- R1: After reset, standby_o is 1, sda_pull_o is 0, and every byte of the array reads as 0x00.
- R2: Before the first start condition, the block ignores clocked bus traffic and never pulls the data line low.
- R3: A start condition (data falls while the clock is high) clears standby_o. The device byte is sent MSB first. It is acknowledged by a low level in the ninth clock slot only when bits 7..4 are 1010 and bits 3..1 equal addr_sel_i. Any other device byte gets no acknowledge, and the bus is then ignored until the next start.
- R4: After a device byte with bit 0 = 0, the next byte loads the pointer. Each later byte is written at the pointer, after which the pointer increments. The slave acknowledges every byte of a write.
- R5: The pointer wraps from 255 to 0, both in writes and in reads.
- R6: After a device byte with bit 0 = 1, the slave sends the byte at the pointer, MSB first, starting on the clock fall that ends the acknowledge slot. The pointer increments after each byte sent.
- R7: In a read, a low level from the master in the ninth slot causes the next byte to be sent. A high level causes the slave to release the line and stay silent until a stop or a start.
- R8: A stop condition (data rises while the clock is high) sets standby_o and releases the line, in any state.
- R9: A repeated start during a transfer behaves like a fresh start, so a dummy write that sets the pointer can be followed by a read from that pointer.
- R10: sda_pull_o changes only after a detected clock falling edge, or a start or stop. It therefore holds steady while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| addr_sel_i | input | 3 | Low three bits of the device address |
| sda_pull_o | output | 1 | Pull data line low when 1 |
| standby_o | output | 1 | High while idle after reset or stop |

## Verification
The assertions assume that the master changes the data line only while the clock is low, except when it is making a start or a stop. They also assume that each bus clock phase lasts longer than the synchroniser and edge-detect delay, so a response driven after a falling edge settles before the next rising edge. The bench master holds each clock phase for eight system cycles and moves data only in the low phase, which keeps the stimulus inside these assumptions. It reads the response at two points in each high phase, which confirms that the response stays steady while the clock is high.

// File: rtl/pd_eeprom_pkg.sv
package pd_eeprom_pkg;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_HOLD
  } pd_state_t;
endpackage

// File: rtl/pd_bus_sync.sv
module pd_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // index 0: clock line, index 1: data line
  logic [1:0] raw, cur, prv;
  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[STAGES-2:0], raw[l]};
    end
    assign cur[l] = ff[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv <= '1;
    else         prv <= cur;
  end

  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prv[0];
  assign scl_fall_o = ~cur[0] & prv[0];
  assign start_o    = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_o     = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/pd_reg_array.sv
module pd_reg_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pd_eeprom_slave.sv
module pd_eeprom_slave import pd_eeprom_pkg::*; #(
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_sel_i,
  output logic       sda_pull_o,
  output logic       standby_o
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  pd_state_t state_q, after_q;
  logic [BYTE_W-1:0] rx_q, tx_q, rdata;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  ptr_q;
  logic mack_q, pull_q, standby_q, we, load_rd, rx_state, byte_in;

  pd_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  pd_reg_array #(.AW(PTR_W), .DW(BYTE_W)) i_array (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(ptr_q), .wdata_i(rx_q),
    .raddr_i(ptr_q), .rdata_o(rdata)
  );

  assign rx_state = (state_q == ST_DEV) || (state_q == ST_PTR) || (state_q == ST_WR);
  assign byte_in  = rx_state && scl_fall && (cnt_q == CNT_FULL);
  assign we       = !start_c && !stop_c && byte_in && (state_q == ST_WR);
  // next read byte is fetched on the fall that closes the ninth slot
  assign load_rd  = scl_fall && (((state_q == ST_ACK) && (after_q == ST_RD)) ||
                                 ((state_q == ST_RACK) && mack_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      after_q   <= ST_IDLE;
      rx_q      <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      mack_q    <= 1'b0;
      pull_q    <= 1'b0;
      standby_q <= 1'b1;
    end else if (stop_c) begin
      state_q   <= ST_IDLE;
      pull_q    <= 1'b0;
      standby_q <= 1'b1;
    end else if (start_c) begin
      state_q   <= ST_DEV;
      pull_q    <= 1'b0;
      standby_q <= 1'b0;
      cnt_q     <= '0;
    end else if (load_rd) begin
      tx_q    <= rdata;
      pull_q  <= ~rdata[BYTE_W-1];
      ptr_q   <= ptr_q + 1'b1;
      cnt_q   <= '0;
      state_q <= ST_RD;
    end else if (rx_state && scl_rise) begin
      rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
      cnt_q <= cnt_q + 1'b1;
    end else if (byte_in) begin
      cnt_q <= '0;
      if (state_q == ST_DEV) begin
        if (rx_q[BYTE_W-1:1] == {DEV_ID, addr_sel_i}) begin
          pull_q  <= 1'b1;
          state_q <= ST_ACK;
          after_q <= rx_q[0] ? ST_RD : ST_PTR;
        end else begin
          state_q <= ST_HOLD;
        end
      end else begin
        if (state_q == ST_PTR) ptr_q <= rx_q;
        else                   ptr_q <= ptr_q + 1'b1;
        pull_q  <= 1'b1;
        state_q <= ST_ACK;
        after_q <= ST_WR;
      end
    end else if (scl_fall) begin
      unique case (state_q)
        ST_ACK: begin
          pull_q  <= 1'b0;
          state_q <= after_q;
        end
        ST_RD: begin
          if (cnt_q == CNT_LAST) begin
            pull_q  <= 1'b0;
            state_q <= ST_RACK;
          end else begin
            tx_q   <= tx_q << 1;
            pull_q <= ~tx_q[BYTE_W-2];
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        ST_RACK: state_q <= ST_HOLD;
        default: ;
      endcase
    end else if (scl_rise && state_q == ST_RACK) begin
      mack_q <= ~sda_s;
    end
  end

  assign sda_pull_o = pull_q;
  assign standby_o  = standby_q;

  a_r10_pull_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_c || stop_c));
  a_r2_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !sda_pull_o);
  a_r8_stop_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> standby_o && !sda_pull_o);
  a_r3_start_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_c && !stop_c) |=> !standby_o && !sda_pull_o);
  a_r4_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK) |-> sda_pull_o);
endmodule

// File: tb/test_pd_eeprom_slave.sv
module test_pd_eeprom_slave;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] sel = 3'd5;
  logic pull, standby;
  logic sda_bus;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sda_bus = m_sda & ~pull;
  always #4 clk = ~clk;

  pd_eeprom_slave i_pd_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel_i(sel), .sda_pull_o(pull), .standby_o(standby)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_h(H);
    scl = 1'b1;   wait_h(H);
    m_sda = 1'b0; wait_h(H);
    scl = 1'b0;   wait_h(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_h(H);
    scl = 1'b1;   wait_h(H);
    m_sda = 1'b1; wait_h(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wait_h(H);
    scl = 1'b1; wait_h(H);
    scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    logic s2;
    m_sda = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(2);
    b = sda_bus; wait_h(H - 2);
    s2 = sda_bus;
    check(s2 == b, "R10 stable while clock high", int'(s2), int'(b));
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~give_ack);
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    wait_h(5);
    check(standby == 1'b1 && pull == 1'b0, "R1 reset outputs", {standby, pull}, 2'b10);
    rst_n = 1'b1;
    wait_h(3);

    // R2: traffic with no start condition
    scl = 1'b0; wait_h(H);
    send_byte({4'b1010, sel, 1'b0}, ack);
    check(ack == 1'b1, "R2 no ack before start", ack, 1);
    check(standby == 1'b1, "R2 still standby", standby, 1);
    bus_stop();

    // R1 + R9: dummy write then read of untouched byte
    bus_start();
    check(standby == 1'b0, "R3 start leaves standby", standby, 0);
    send_byte({4'b1010, sel, 1'b0}, ack);
    check(ack == 1'b0, "R3 device ack", ack, 0);
    send_byte(8'h05, ack);
    check(ack == 1'b0, "R4 pointer ack", ack, 0);
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack);
    check(ack == 1'b0, "R9 read after repeated start ack", ack, 0);
    recv_byte(v, 1'b0);
    check(v == 8'h00, "R1 array cleared", v, 0);
    bus_stop();
    check(standby == 1'b1, "R8 stop gives standby", standby, 1);

    // R3: address select sweep
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte({4'b1010, 3'(a), 1'b0}, ack);
        check(ack == (a != s), "R3 address match", ack, int'(a != s));
        if (a != s) begin
          send_byte(8'h00, ack);
          check(ack == 1'b1, "R3 ignored after mismatch", ack, 1);
        end
        bus_stop();
      end
    end
    sel = 3'd6;
    bus_start();
    send_byte({4'b1011, sel, 1'b0}, ack);
    check(ack == 1'b1, "R3 wrong upper nibble", ack, 1);
    bus_stop();

    // R4/R5: full sequential write from 0x80, wrapping
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    check(ack == 1'b0, "R4 device ack", ack, 0);
    send_byte(8'h80, ack);
    for (int i = 0; i < 256; i++) begin
      send_byte(pat((i + 128) & 255), ack);
      check(ack == 1'b0, "R4 data ack", ack, 0);
    end
    bus_stop();
    check(standby == 1'b1, "R8 standby after write", standby, 1);

    // R5/R6: current-address read, pointer wrapped back to 0x80
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack);
    check(ack == 1'b0, "R6 read device ack", ack, 0);
    recv_byte(v, 1'b0);
    check(v == pat(128), "R5 R6 current address read", v, pat(128));
    bus_stop();

    // R7: sequential read across the wrap, then no-ack
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack);
    for (int i = 0; i < 257; i++) begin
      recv_byte(v, i != 256);
      check(v == pat((129 + i) & 255), "R7 sequential read", v, pat((129 + i) & 255));
    end
    for (int i = 0; i < 9; i++) begin
      get_bit(ack);
      check(ack == 1'b1, "R7 silent after no-ack", ack, 1);
    end
    bus_stop();
    check(standby == 1'b1 && pull == 1'b0, "R8 stop after no-ack", {standby, pull}, 2'b10);

    // R9: dummy write at 0x33 then read
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    send_byte(8'h33, ack);
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack);
    recv_byte(v, 1'b1);
    check(v == pat(8'h33), "R9 dummy write then read", v, pat(8'h33));
    recv_byte(v, 1'b0);
    check(v == pat(8'h34), "R6 pointer increments", v, pat(8'h34));
    bus_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule